// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side protocol engine for a 256-byte serial memory reached over a two-wire bus with a clock line and a data line. It oversamples both bus lines with the system clock and finds bus start and stop conditions. It receives a device byte and compares it with a fixed type code and three pin-strapped select bits. It acknowledges, takes a word address, and then either receives data bytes or shifts stored bytes out, most significant bit first. The open-drain pad is modelled by `sda_pull_low`: when this output is high the pad pulls the line low, and when it is low the line is released.

Accepted write bytes are offered to a memory-side controller on a valid/ready byte channel. `wr_valid` is a one-cycle offer, and `mem_addr` carries the target address during that cycle. The rule for back-pressure is as follows. If `wr_ready` is low in the offer cycle, the byte is dropped and the slave does not acknowledge it, so the bus master learns of the refusal at once; the offer is not held. A stop that ends a write carrying at least one accepted byte produces a one-cycle `commit`. The controller may then raise `busy`, and while `busy` is high the engine ignores the bus completely. A host can therefore poll for the end of the write cycle by retrying the device byte until it is acknowledged.

Read data comes back through `mem_rdata`, which must reflect `mem_addr` in the same cycle, as a register-file read port does. One address counter serves reads and writes and keeps its value between transactions. The system clock must run at least 8 times faster than the bus clock.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset, `sda_pull_low`, `wr_valid` and `commit` are 0 and `mem_addr` is 0.
- R2: A falling data line while the bus clock is high is a start, and a rising data line while the bus clock is high is a stop. Changes while the bus clock is low are data bits, which are sampled on the rising bus clock. The engine changes its drive on the data line only while the synchronized bus clock is low.
- R3: A device byte is acknowledged only if it equals {4'b1010, dev_sel[2:0], rw}, sent MSB first. Bit 0 = 1 selects read and 0 selects write. After a mismatch the engine acknowledges nothing until the next start.
- R4: In a write, the word address is acknowledged, and each data byte is offered on `wr_valid` with `wr_data` and `mem_addr`. The byte is acknowledged if `wr_ready` is high in that cycle.
- R5: After each accepted data byte, the two low address bits advance and wrap within the 4-byte page while the upper six bits stay the same. A fifth byte therefore overwrites the first byte's address.
- R6: A stop after a write with at least one accepted data byte gives exactly one single-cycle `commit`. A stop after a write with no accepted data byte gives none.
- R7: A read sends 8 bits MSB first and then releases the line. If the master acknowledges (line low on the 9th clock), the next byte follows. If it does not, the line stays released until the next start.
- R8: A read with no preceding word address returns the byte at the last accessed address plus one, whether that last access was a read or a write.
- R9: In a random read (a word address, then a repeated start, then a read), the word address loads the counter and causes no `wr_valid` and no `commit`.
- R10: During reads, the counter increments across all 8 bits and wraps from 255 to 0.
- R11: While `busy` is high the engine does not drive the line, acknowledges nothing (its own device byte included), and raises neither `wr_valid` nor `commit`.
- R12: A start at any point abandons the transfer in progress and begins device-byte reception, leaving the counter as it was. A stop returns the engine to idle, where bus clocks without a start are ignored.
- R13: A byte refused by a low `wr_ready` is not acknowledged, does not advance the counter, and does not count toward `commit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired result) |
| sda_pull_low | output | 1 | 1 = pull the data line low |
| dev_sel | input | 3 | Pin-strapped device select bits |
| mem_addr | output | 8 | Address counter, the read and write target |
| mem_rdata | input | 8 | Byte stored at `mem_addr` |
| wr_valid | output | 1 | One-cycle offer of a received data byte |
| wr_ready | input | 1 | Controller accepts the offered byte |
| wr_data | output | 8 | Offered data byte |
| commit | output | 1 | One-cycle pulse: start the write cycle |
| busy | input | 1 | Write cycle in progress; the engine ignores the bus |

## Verification
A wrong state shows up at the ports within one byte time, as an acknowledge bit with the wrong level on the data line or as a read byte whose bits are shifted or belong to the wrong address. A counter that is out of step is not seen during the transaction that corrupts it. It appears on the next current-address read, which is why the tests chain such reads after writes, reads, refused bytes and aborted addresses. A broken busy gate or a broken page wrap shows as an acknowledge during polling, or as readback data at an address outside the 4-byte page.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int TW_BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_WOFFER,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_SKIP
  } tw_state_e;
endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  // Both lines idle high, so reset to 1 to avoid a false condition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int AW = 8,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_page,
  input  logic          step_all,
  output logic [AW-1:0] cnt
);
  localparam logic [AW-1:0] ONE_A = 1;
  localparam logic [PW-1:0] ONE_P = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (step_all)  cnt <= cnt + ONE_A;
    else if (step_page) cnt <= {cnt[AW-1:PW], cnt[PW-1:0] + ONE_P};
  end

  // R5: a page step leaves the upper bits where they were
  a_r5_page_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !load && !step_all) |=> (cnt[AW-1:PW] == $past(cnt[AW-1:PW])));

  // R10: a full step from the top address lands on zero
  a_r10_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_all && !load && (cnt == '1)) |=> (cnt == '0));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import tw_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          PAGE_BITS = 2,
  parameter int          SYNC_LEN  = 2,
  parameter logic [3:0]  TYPE_ID   = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull_low,
  input  logic [2:0]    dev_sel,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [7:0]    wr_data,
  output logic          commit,
  input  logic          busy
);
  localparam int             CW        = $clog2(TW_BYTE_W + 1);
  localparam logic [CW-1:0]  CNT_FULL  = CW'(TW_BYTE_W);
  localparam logic [CW-1:0]  CNT_ONE   = 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  tw_state_e st, ack_nxt;
  logic [CW-1:0] bitcnt;
  logic [7:0]    sr, sh;
  logic          mack, wr_any, live, byte_end;
  logic          ctr_load, ctr_step_page, ctr_step_all;

  tw_bus_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  always_comb begin
    live          = !busy && !start_det && !stop_det;
    byte_end      = scl_fall && (bitcnt == CNT_FULL);
    ctr_load      = live && (st == ST_WADDR) && byte_end;
    ctr_step_page = live && (st == ST_WOFFER) && wr_ready;
    ctr_step_all  = live && (st == ST_TX) && byte_end;
  end

  tw_addr_ctr #(.AW(AW), .PW(PAGE_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(sr[AW-1:0]),
    .step_page(ctr_step_page), .step_all(ctr_step_all), .cnt(mem_addr)
  );

  assign wr_data = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      ack_nxt      <= ST_IDLE;
      bitcnt       <= '0;
      sr           <= '0;
      sh           <= '0;
      mack         <= 1'b0;
      wr_any       <= 1'b0;
      sda_pull_low <= 1'b0;
      wr_valid     <= 1'b0;
      commit       <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      commit   <= 1'b0;
      if (busy) begin
        st           <= ST_IDLE;
        sda_pull_low <= 1'b0;
      end else if (stop_det) begin
        st           <= ST_IDLE;
        sda_pull_low <= 1'b0;
        commit       <= wr_any;
        wr_any       <= 1'b0;
      end else if (start_det) begin
        st           <= ST_DEV;
        bitcnt       <= '0;
        sda_pull_low <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              sr     <= {sr[6:0], sda_lvl};
              bitcnt <= bitcnt + CNT_ONE;
            end else if (byte_end) begin
              bitcnt <= '0;
              if (st == ST_DEV) begin
                if (sr[7:1] == {TYPE_ID, dev_sel}) begin
                  sda_pull_low <= 1'b1;
                  st           <= ST_ACK;
                  ack_nxt      <= sr[0] ? ST_TX : ST_WADDR;
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_WADDR) begin
                sda_pull_low <= 1'b1;
                st           <= ST_ACK;
                ack_nxt      <= ST_WDATA;
              end else begin
                wr_valid <= 1'b1;
                st       <= ST_WOFFER;
              end
            end
          end
          ST_WOFFER: begin
            if (wr_ready) begin
              sda_pull_low <= 1'b1;
              wr_any       <= 1'b1;
              st           <= ST_ACK;
              ack_nxt      <= ST_WDATA;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              st     <= ack_nxt;
              if (ack_nxt == ST_TX) begin
                sh           <= mem_rdata;
                sda_pull_low <= ~mem_rdata[7];
              end else begin
                sda_pull_low <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + CNT_ONE;
            end else if (byte_end) begin
              sda_pull_low <= 1'b0;
              bitcnt       <= '0;
              st           <= ST_RACK;
            end else if (scl_fall) begin
              sh           <= {sh[6:0], 1'b0};
              sda_pull_low <= ~sh[6];
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                sh           <= mem_rdata;
                sda_pull_low <= ~mem_rdata[7];
                st           <= ST_TX;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a busy controller silences the engine from the next cycle
  a_r11_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!sda_pull_low && !wr_valid && !commit));

  // R2: drive changes only follow a low synchronized bus clock
  a_r2_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_low) && !$past(busy)) |-> !$past(scl_lvl));

  // R6: commit never lasts more than one cycle
  a_r6_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R4: each byte offer is a single-cycle pulse
  a_r4_offer_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R12: a start releases the data line
  a_r12_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !busy) |=> !sda_pull_low);
endmodule

// File: tb/sim_twowire_mem_slave.sv
module sim_twowire_mem_slave;
  localparam int         Q    = 5;
  localparam logic [2:0] SEL  = 3'b101;
  localparam logic [7:0] DW   = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DR   = {4'b1010, SEL, 1'b1};
  localparam int         NV   = 6;
  // {word address, data}
  localparam logic [15:0] VEC [NV] = '{16'h103C, 16'h11C3, 16'h7F00,
                                       16'hFFFF, 16'h0081, 16'h42A5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull_low, wr_valid, commit, busy;
  logic wr_ready_en = 1'b1;
  logic [7:0] mem_addr, mem_rdata, wr_data;
  wire sda_bus = m_sda & ~sda_pull_low;

  twowire_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_pull_low(sda_pull_low), .dev_sel(SEL), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready_en),
    .wr_data(wr_data), .commit(commit), .busy(busy)
  );

  // memory-side controller model
  logic [7:0] mem [256];
  logic [7:0] pa [16];
  logic [7:0] pd [16];
  logic [7:0] slog_a [64];
  logic [7:0] slog_d [64];
  int pn, nstrobe, ncommit, busy_cnt;
  assign mem_rdata = mem[mem_addr];
  assign busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      pn <= 0; nstrobe <= 0; ncommit <= 0; busy_cnt <= 0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (wr_valid && wr_ready_en) begin
        pa[pn % 16] <= mem_addr;
        pd[pn % 16] <= wr_data;
        pn <= pn + 1;
        slog_a[nstrobe % 64] <= mem_addr;
        slog_d[nstrobe % 64] <= wr_data;
        nstrobe <= nstrobe + 1;
      end
      if (commit) begin
        for (int k = 0; k < 16; k++) if (k < pn) mem[pa[k]] <= pd[k];
        pn <= 0;
        busy_cnt <= 400;
        ncommit <= ncommit + 1;
      end
    end
  end

  logic [7:0] shadow [256];
  int total = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wbit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); b = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bstart();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(2*Q); m_sda = 1'b0; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(2*Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output logic nk);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(nk);
  endtask

  task automatic recv(output logic [7:0] d, input logic mk);
    logic bb;
    d = '0;
    for (int i = 0; i < 8; i++) begin rbit(bb); d = {d[6:0], bb}; end
    wbit(mk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) tick(1);
  endtask

  logic n0, n1, n2, nk;
  logic [7:0] rd, r1, r2, r3;
  logic [8:0] tail;
  int ns0, nc0;

  initial begin
    repeat (800000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 reset outputs", {29'd0, sda_pull_low, wr_valid, commit}, 32'd0);
    chk("R1 reset counter", {24'd0, mem_addr}, 32'd0);

    // vector table: byte write then random read back
    for (int v = 0; v < NV; v++) begin
      logic [7:0] a, d;
      a = VEC[v][15:8]; d = VEC[v][7:0];
      ns0 = nstrobe; nc0 = ncommit;
      bstart(); send(DW, n0); send(a, n1); send(d, n2); bstop(); tick(2);
      chk("R3/R4 write acks", {29'd0, n0, n1, n2}, 32'd0);
      chk("R4 one strobe", nstrobe - ns0, 1);
      chk("R4 strobe addr/data", {16'd0, slog_a[ns0 % 64], slog_d[ns0 % 64]}, {16'd0, a, d});
      chk("R6 one commit", ncommit - nc0, 1);
      shadow[a] = d;
      wait_idle();
      ns0 = nstrobe; nc0 = ncommit;
      bstart(); send(DW, n0); send(a, n1); bstart(); send(DR, n2);
      recv(rd, 1'b1); bstop(); tick(2);
      chk("R2/R9 random readback", {24'd0, rd}, {24'd0, d});
      chk("R9 dummy write silent", {ns0 == nstrobe, nc0 == ncommit}, 2'b11);
    end

    // R3: wrong select bits and wrong type code
    ns0 = nstrobe; nc0 = ncommit;
    bstart(); send({4'b1010, 3'b001, 1'b0}, n0); send(8'h00, n1); bstop();
    bstart(); send({4'b1011, SEL, 1'b0}, n2); bstop(); tick(2);
    chk("R3 mismatch no ack", {29'd0, n0, n1, n2}, 32'd7);
    chk("R3 mismatch no strobe/commit", {ns0 == nstrobe, nc0 == ncommit}, 2'b11);

    // R11: acknowledge polling while busy
    bstart(); send(DW, n0); send(8'h20, n1); send(8'h99, n2); bstop();
    shadow[8'h20] = 8'h99;
    bstart(); send(DW, nk); bstop();
    chk("R11 busy no ack", {31'd0, nk}, 32'd1);
    wait_idle();
    nc0 = ncommit;
    bstart(); send(DW, nk); bstop(); tick(2);
    chk("R11 ack after busy", {31'd0, nk}, 32'd0);
    chk("R6 no commit without data", ncommit - nc0, 0);

    // R5: five bytes from 0x36 wrap inside the page
    ns0 = nstrobe;
    bstart(); send(DW, n0); send(8'h36, n1);
    for (int k = 0; k < 5; k++) begin
      send(8'h11 * 8'(k + 1), nk);
      chk("R4 page byte ack", {31'd0, nk}, 32'd0);
    end
    bstop(); tick(2);
    for (int k = 0; k < 5; k++)
      chk("R5 page strobe addr", {24'd0, slog_a[(ns0 + k) % 64]},
          {24'd0, 6'b001101, 2'(k + 2)});
    shadow[8'h36] = 8'h55; shadow[8'h37] = 8'h22;
    shadow[8'h34] = 8'h33; shadow[8'h35] = 8'h44;
    wait_idle();

    // R8: current address after the last page write at 0x36
    bstart(); send(DR, nk); recv(rd, 1'b1); bstop();
    chk("R8 current after write", {24'd0, rd}, {24'd0, shadow[8'h37]});

    // sequential read from 0x34
    bstart(); send(DW, n0); send(8'h34, n1); bstart(); send(DR, n2);
    recv(rd, 1'b0); recv(r1, 1'b0); recv(r2, 1'b0); recv(r3, 1'b1); bstop();
    chk("R7/R5 sequential page data", {rd, r1, r2, r3},
        {shadow[8'h34], shadow[8'h35], shadow[8'h36], shadow[8'h37]});
    bstart(); send(DR, nk); recv(rd, 1'b1); bstop();
    chk("R8 current after read", {24'd0, rd}, {24'd0, shadow[8'h38]});

    // R10: wrap 255 -> 0, then R7: silence after no acknowledge
    bstart(); send(DW, n0); send(8'hFE, n1); bstart(); send(DR, n2);
    recv(rd, 1'b0); recv(r1, 1'b0); recv(r2, 1'b1);
    chk("R10 wrap data", {8'd0, rd, r1, r2}, {8'd0, shadow[8'hFE], shadow[8'hFF], shadow[8'h00]});
    tail = '0;
    for (int i = 0; i < 9; i++) begin logic bb; rbit(bb); tail = {tail[7:0], bb}; end
    bstop();
    chk("R7 released after no ack", {23'd0, tail}, {23'd0, 9'h1FF});

    // R13: refused byte
    wr_ready_en = 1'b0;
    ns0 = nstrobe; nc0 = ncommit;
    bstart(); send(DW, n0); send(8'h50, n1); send(8'h77, n2); bstop(); tick(2);
    chk("R13 refused byte no ack", {29'd0, n0, n1, n2}, 32'd1);
    chk("R13 no handshake, no commit", {ns0 == nstrobe, nc0 == ncommit}, 2'b11);
    wr_ready_en = 1'b1;
    bstart(); send(DR, nk); recv(rd, 1'b1); bstop();
    chk("R13 counter not advanced", {24'd0, rd}, {24'd0, shadow[8'h50]});

    // R12: start in the middle of a word address
    bstart(); send(DW, n0); wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0);
    bstart(); send(DR, nk); recv(rd, 1'b1); bstop();
    chk("R12 abort keeps counter", {23'd0, nk, rd}, {23'd0, 1'b0, shadow[8'h51]});

    // R12: idle ignores clocks without a start
    m_scl = 1'b0; tick(Q);
    send(DW, nk);
    m_scl = 1'b1; tick(2*Q);
    chk("R12 idle ignores byte", {31'd0, nk}, 32'd1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule